// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a memory-mapped SPI master that runs a single flash command each time software triggers it. Software programs an opcode register and a packed byte-count register, then fills an 8-slot ring buffer through one auto-incrementing data port. Setting the execute bit starts the command. The engine drives chip select low, shifts out the opcode, then the transmit bytes from the buffer, then clocks in the response bytes while driving zeros on MOSI. It then releases chip select and clears the execute bit.

Transmit and receive data share the same ring buffer, and the buffer is never cleared. Every byte clocked after the opcode writes the byte seen on MISO back into the buffer. The slot that held transmit byte k ends up holding the response to it, and the response bytes follow in the next slots, wrapping past slot 7. Software reads the results by resetting the buffer pointer, discarding the transmit-count slots and reading the rest through the data port. The SPI clock is the system clock divided by a parameter. The bus runs in mode 0, most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, the buffer pointer reads 0 and the execute bit reads 0.
- R2: Offset 0x0 holds the opcode. Offset 0x1 holds the receive count in bits 7:4 and the transmit count (opcode excluded) in bits 3:0. Both read back as written.
- R3: A write or read at offset 0xC accesses the buffer slot at the pointer, and the access then advances the pointer by one, modulo 8. Bits 2:0 of offset 0xD read the pointer, and bits 7:3 read 0.
- R4: Writing offset 0x2 with bit 4 set returns the pointer to 0 on the next cycle. Bit 4 always reads 0.
- R5: Writing offset 0x2 with bit 0 set starts a command. Bit 0 reads 1 while the command runs and returns to 0 only after chip select has gone high again.
- R6: On MOSI a command is the opcode, then transmit bytes from slots 0 to N-1, then one 0x00 byte per receive byte. Bytes go MSB first in mode 0: SCLK idles low, and MISO is sampled on the rising edge.
- R7: The byte received during data byte d (d = 1 for the first byte after the opcode) is stored in slot (d-1) mod 8. The response to the opcode is discarded.
- R8: Chip select goes low before the first rising SCLK edge. It goes high only after all 8*(1+N+M) rising edges, including when the transmit count N is 0.
- R9: A count field value above 8 is treated as 8.
- R10: While a command runs, writes to offsets 0x0, 0x1, 0x2 and 0xC are ignored. A read at 0xC while a command runs does not move the pointer.
- R11: Buffer slots that a command does not reach keep their earlier contents.
- R12: Each SCLK half period lasts HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (advances the pointer at 0xC) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI master-out data |
| miso_i | input | 1 | SPI master-in data |

## Verification
The assertions check the following on every cycle:
- chip select stays low for the whole time the execute bit is set;
- SCLK is low whenever chip select is high;
- the execute bit only falls with chip select already high;
- the pointer holds while a command runs;
- the pointer returns to 0 after a pointer reset;
- the pointer advances by one per idle data-port access.

Only the bench scenarios can show the byte-level results:
- the opcode and transmit bytes arrive on MOSI in order;
- responses land in the right slots, including when they wrap;
- the number of clock edges matches the counts, with no final byte lost when the transmit count is 0;
- counts above 8 are clamped;
- untouched slots keep their old data;
- the SCLK half-period length is correct.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned BUF_DEPTH = 8;
  localparam int unsigned PTR_W     = $clog2(BUF_DEPTH);
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned IDX_W     = CNT_W + 1;

  localparam logic [3:0] OFF_OPCODE = 4'h0;
  localparam logic [3:0] OFF_COUNT  = 4'h1;
  localparam logic [3:0] OFF_CTRL   = 4'h2;
  localparam logic [3:0] OFF_DATA   = 4'hC;
  localparam logic [3:0] OFF_PTR    = 4'hD;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned CTRL_PRST_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TRAIL
  } eng_state_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_ring_buf.sv
module spi_ring_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_we_i,
  input  logic [AW-1:0] port_addr_i,
  input  logic [W-1:0]  port_wdata_i,
  output logic [W-1:0]  port_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_waddr_i,
  input  logic [W-1:0]  eng_wdata_i,
  input  logic [AW-1:0] eng_raddr_i,
  output logic [W-1:0]  eng_rdata_o
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[i] <= '0;
      else if (eng_we_i && eng_waddr_i == AW'(i))     slot_q[i] <= eng_wdata_i;
      else if (port_we_i && port_addr_i == AW'(i))    slot_q[i] <= port_wdata_i;
    end
  end

  assign port_rdata_o = slot_q[port_addr_i];
  assign eng_rdata_o  = slot_q[eng_raddr_i];
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       opcode_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [IDX_W-1:0] total_i,
  input  logic             tick_i,
  output logic             div_en_o,
  output logic [AW-1:0]    buf_raddr_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_we_o,
  output logic [AW-1:0]    buf_waddr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  eng_state_e     state_q;
  logic [7:0]     sh_out_q, sh_in_q;
  logic [2:0]     bit_q;
  logic [IDX_W-1:0] byte_q;
  logic           sclk_q, cs_nq;
  logic           byte_end;
  logic [7:0]     nxt_byte;

  assign busy_o   = (state_q != ST_IDLE);
  assign div_en_o = busy_o;
  assign sclk_o   = sclk_q;
  assign cs_no    = cs_nq;
  assign mosi_o   = sh_out_q[7];

  assign byte_end    = (state_q == ST_SHIFT) && tick_i && sclk_q && (bit_q == 3'd7);
  // next data byte d = byte_q+1 lives in slot byte_q
  assign buf_raddr_o = byte_q[AW-1:0];
  assign nxt_byte    = (byte_q < IDX_W'(tx_cnt_i)) ? buf_rdata_i : 8'h00;
  // opcode response (byte 0) is dropped
  assign buf_we_o    = byte_end && (byte_q != '0);
  assign buf_waddr_o = AW'(byte_q - 1'b1);
  assign buf_wdata_o = sh_in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_out_q <= '0;
      sh_in_q  <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      sclk_q   <= 1'b0;
      cs_nq    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_SHIFT;
          cs_nq    <= 1'b0;
          sclk_q   <= 1'b0;
          sh_out_q <= opcode_i;
          sh_in_q  <= '0;
          bit_q    <= '0;
          byte_q   <= '0;
        end
        ST_SHIFT: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q  <= 1'b1;
            sh_in_q <= {sh_in_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (byte_q == total_i) begin
                state_q <= ST_TRAIL;
              end else begin
                byte_q   <= byte_q + 1'b1;
                sh_out_q <= nxt_byte;
              end
            end else begin
              bit_q    <= bit_q + 1'b1;
              sh_out_q <= {sh_out_q[6:0], 1'b0};
            end
          end
        end
        ST_TRAIL: if (tick_i) begin
          cs_nq   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  cs_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cs_no);
  // R6
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R5
  busy_fall_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cs_no);
  // R6
  sclk_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $stable(sclk_o));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(BUF_DEPTH);

  logic [7:0]       opcode_q, count_q;
  logic [PTR_W-1:0] ptr_q;
  logic             busy, tick, div_en;
  logic             wr_ok, wr_op, wr_cnt, wr_ctrl, data_wr, data_rd;
  logic             start, ptr_rst;
  logic [CNT_W-1:0] tx_raw, rx_raw, tx_eff, rx_eff;
  logic [IDX_W-1:0] total;
  logic [PTR_W-1:0] eng_raddr, eng_waddr;
  logic [7:0]       eng_rdata, eng_wdata, port_rdata;
  logic             eng_we;

  assign wr_ok   = reg_wr_i && !busy;
  assign wr_op   = wr_ok && reg_addr_i == OFF_OPCODE;
  assign wr_cnt  = wr_ok && reg_addr_i == OFF_COUNT;
  assign wr_ctrl = wr_ok && reg_addr_i == OFF_CTRL;
  assign data_wr = wr_ok && reg_addr_i == OFF_DATA;
  assign data_rd = reg_rd_i && !busy && reg_addr_i == OFF_DATA;
  assign start   = wr_ctrl && reg_wdata_i[CTRL_GO_BIT];
  assign ptr_rst = wr_ctrl && reg_wdata_i[CTRL_PRST_BIT];

  assign tx_raw = count_q[CNT_W-1:0];
  assign rx_raw = count_q[7:4];
  assign tx_eff = (tx_raw > MAX_CNT) ? MAX_CNT : tx_raw;
  assign rx_eff = (rx_raw > MAX_CNT) ? MAX_CNT : rx_raw;
  assign total  = IDX_W'(tx_eff) + IDX_W'(rx_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= '0;
      count_q  <= '0;
      ptr_q    <= '0;
    end else begin
      if (wr_op)  opcode_q <= reg_wdata_i;
      if (wr_cnt) count_q  <= reg_wdata_i;
      if (ptr_rst)                 ptr_q <= '0;
      else if (data_wr || data_rd) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFF_OPCODE: reg_rdata_o = opcode_q;
      OFF_COUNT:  reg_rdata_o = count_q;
      OFF_CTRL:   reg_rdata_o = {7'b0, busy};
      OFF_DATA:   reg_rdata_o = port_rdata;
      OFF_PTR:    reg_rdata_o = {{(8-PTR_W){1'b0}}, ptr_q};
      default:    reg_rdata_o = 8'h00;
    endcase
  end

  spi_ring_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .port_we_i    (data_wr),
    .port_addr_i  (ptr_q),
    .port_wdata_i (reg_wdata_i),
    .port_rdata_o (port_rdata),
    .eng_we_i     (eng_we),
    .eng_waddr_i  (eng_waddr),
    .eng_wdata_i  (eng_wdata),
    .eng_raddr_i  (eng_raddr),
    .eng_rdata_o  (eng_rdata)
  );

  spi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div_en),
    .tick_o (tick)
  );

  spi_shift_ctrl #(.AW(PTR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .opcode_i    (opcode_q),
    .tx_cnt_i    (tx_eff),
    .total_i     (total),
    .tick_i      (tick),
    .div_en_o    (div_en),
    .buf_raddr_o (eng_raddr),
    .buf_rdata_i (eng_rdata),
    .buf_we_o    (eng_we),
    .buf_waddr_o (eng_waddr),
    .buf_wdata_o (eng_wdata),
    .busy_o      (busy),
    .sclk_o      (sclk_o),
    .cs_no       (cs_no),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i)
  );

  // R10
  ptr_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(ptr_q));
  // R4
  ptr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !busy && reg_addr_i == OFF_CTRL && reg_wdata_i[CTRL_PRST_BIT])
      |=> (ptr_q == '0));
  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_wr_i || reg_rd_i) && !busy && reg_addr_i == OFF_DATA)
      |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int HALF_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk, cs_n, mosi, miso;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [8];
  logic [7:0] seed = 8'h00;

  // slave model
  int  s_bits = 0, s_rises = 0, rel_rises = 0;
  logic [7:0] s_sh = '0;
  logic [7:0] mosi_log [17];
  time t_r1 = 0, t_r2 = 0;

  spi_cmd_engine #(.HALF_DIV(HALF_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  always #5 clk = ~clk;

  function automatic logic [7:0] resp(input int d);
    return seed + 8'(d) * 8'h13;
  endfunction

  always_comb begin
    logic [7:0] b;
    b = resp(s_bits / 8);
    miso = cs_n ? 1'b0 : b[7 - (s_bits % 8)];
  end

  always @(negedge cs_n) begin s_bits = 0; s_rises = 0; end
  always @(posedge cs_n) rel_rises = s_rises;
  always @(posedge sclk) if (!cs_n) begin
    s_sh = {s_sh[6:0], mosi};
    s_rises++;
    if (s_rises == 1) t_r1 = $time;
    if (s_rises == 2) t_r2 = $time;
    s_bits++;
    if (s_bits % 8 == 0 && s_bits / 8 <= 17) mosi_log[s_bits/8 - 1] = s_sh;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 5000; i++) begin
      peek(4'h2, c);
      if (c[0] == 1'b0) return;
    end
    check("R5", "command never completed", 1, 0);
  endtask

  task automatic check_buf(input string req);
    logic [7:0] d;
    reg_wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      reg_rd(4'hC, d);
      check(req, $sformatf("slot %0d", i), d, model[i]);
    end
  endtask

  // full command: load tx, run, check bus and buffer
  task automatic run_cmd(input logic [7:0] op, input int txr, input int rxr,
                         input logic [7:0] s, input string req);
    int te, re, tot;
    te = txr > 8 ? 8 : txr;
    re = rxr > 8 ? 8 : rxr;
    tot = te + re;
    seed = s;
    reg_wr(4'h0, op);
    reg_wr(4'h1, 8'((rxr << 4) | txr));
    reg_wr(4'h2, 8'h10);
    for (int i = 0; i < te; i++) begin
      reg_wr(4'hC, 8'hC0 + 8'(i) + s);
      model[i] = 8'hC0 + 8'(i) + s;
    end
    reg_wr(4'h2, 8'h10);
    reg_wr(4'h2, 8'h01);
    wait_idle();
    // R8: all edges seen before release
    check("R8", "rising edges before cs release", rel_rises, 8 * (1 + tot));
    // R6
    check("R6", "opcode on mosi", mosi_log[0], op);
    for (int d = 1; d <= tot; d++) begin
      check("R6", $sformatf("mosi byte %0d", d), mosi_log[d],
            d <= te ? model[d-1] : 8'h00);
    end
    // R7 / R11 model update
    for (int d = 1; d <= tot; d++) model[(d-1) % 8] = resp(d);
    check_buf(req);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", "cs_n after reset", cs_n, 1);
    check("R1", "sclk after reset", sclk, 0);
    peek(4'hD, d); check("R1", "pointer after reset", d, 0);
    peek(4'h2, d); check("R1", "exec bit after reset", d, 0);
  endtask

  task automatic t_regs_ptr();
    logic [7:0] d;
    reg_wr(4'h0, 8'h9F); reg_wr(4'h1, 8'h35);
    peek(4'h0, d); check("R2", "opcode readback", d, 8'h9F);
    peek(4'h1, d); check("R2", "count readback", d, 8'h35);
    reg_wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) begin
      reg_wr(4'hC, 8'h10 + 8'(i));
      model[i % 8] = 8'h10 + 8'(i);
    end
    peek(4'hD, d); check("R3", "pointer wraps after 9 writes", d, 1);
    reg_wr(4'h2, 8'h10);
    peek(4'hD, d); check("R4", "pointer reset", d, 0);
    peek(4'h2, d); check("R4", "ctrl bit4 reads 0", d & 8'h10, 0);
    reg_rd(4'hC, d); check("R3", "slot0 holds 9th write", d, 8'h18);
    peek(4'hD, d); check("R3", "pointer after read", d, 1);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d, p0;
    reg_wr(4'h0, 8'h05); reg_wr(4'h1, 8'h40);
    reg_wr(4'h2, 8'h10);
    reg_wr(4'h2, 8'h01);
    seed = 8'h77;
    peek(4'h2, d); check("R5", "exec bit reads 1 while running", d & 1, 1);
    peek(4'hD, p0);
    reg_wr(4'h0, 8'h55); reg_wr(4'h1, 8'h11); reg_wr(4'hC, 8'h99);
    reg_wr(4'h2, 8'h10); reg_rd(4'hC, d);
    peek(4'hD, d); check("R10", "pointer during busy", d, p0);
    wait_idle();
    check("R5", "cs high once exec clears", cs_n, 1);
    peek(4'h0, d); check("R10", "opcode kept", d, 8'h05);
    peek(4'h1, d); check("R10", "count kept", d, 8'h40);
    check("R10", "tx=0 rx=4 edges", rel_rises, 40);
    for (int k = 1; k <= 4; k++) model[k-1] = resp(k);
    check_buf("R10");
  endtask

  initial begin
    #(200000 * 10);
    check("WDOG", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    #23 rst_n = 1'b1;
    t_reset();
    t_regs_ptr();
    run_cmd(8'h03, 3, 2, 8'h21, "R7");
    check("R12", "sclk period", int'(t_r2 - t_r1), 2 * HALF_DIV * 10);
    // R8: opcode only transmit, response must be complete
    run_cmd(8'h9F, 0, 3, 8'h42, "R8");
    // wrap past slot 7
    run_cmd(8'h0B, 6, 5, 8'h63, "R7");
    // R11: short command leaves slots 2..7 untouched
    run_cmd(8'h05, 1, 1, 8'h84, "R11");
    // R9: raw counts 15/9 clamp to 8/8
    run_cmd(8'hAB, 9, 15, 8'hA5, "R9");
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule